// File: doc/BRIEF.md
# NAND flash opcode sequencer

This block drives an 8-bit NAND flash command/data bus from a short program. The host loads eight 4-bit opcodes into a program register and starts the block with a one-cycle strobe. Each opcode is one step of a flash transaction. A step can be a command byte taken from a bank of four stored bytes, column or page address bytes, a single byte moved through a 32-bit scratch register, or a burst between an external byte-wide buffer RAM and the device. Four opcodes first wait for the ready/busy line, up to a programmable limit.

Every bus byte takes two clock cycles. In the first cycle the strobe (WE# or RE#) is low. In the second it is high again. CLE or ALE and the driven data stay valid for both cycles. Read data is sampled on the clock edge that raises RE#. The host reads single-byte results from the scratch register output. It reads burst results from its own buffer RAM.

Register map (`cfg_sel`): 0 is the program (slot 0 in bits 31:28, slot 7 in bits 3:0). 1 is the command bytes. 2 is the scratch register. 3 is the column address. 4 is the page address. 5 is the geometry and timing word. Codes 6 and 7 have no effect.

Top module: `nand_opseq`

## Requirements
- R1: After reset the block is idle: busy, done and timeout are 0, WE#/RE# are high, CLE/ALE/output-enable are low, and the scratch and command registers are zero.
- R2: Slots run in order from slot 0 (bits 31:28) to slot 7 (bits 3:0). When slot 7 completes, busy falls and done rises in the same cycle. A program of eight command opcodes keeps busy high for exactly 16 cycles.
- R3: Opcode 0000 ends the sequence. It costs one idle cycle, then done is set, and no later slot runs. Done stays high until the next start.
- R4: Opcodes 0100, 0101, 0110 and 0111 issue command byte 0, 1, 2 and 3. Command 0 is in bits 31:24 of register 1 and command 3 is in bits 7:0. The cycle has CLE high for two cycles, WE# low only in the first cycle, and the byte driven.
- R5: Opcode 0001 sends the column address with ALE, low byte first. It sends 2 bytes when geometry bit 0 is 1 and 1 byte otherwise. Opcode 0010 sends the page address, low byte first, with (bits 2:1)+1 bytes.
- R6: Opcode 0011 (with ALE) and opcode 1001 (with neither CLE nor ALE) drive the scratch field selected by a shared field pointer. Field 0 is bits 31:24 and field 3 is bits 7:0. The pointer advances after each use and wraps from 3 to 0.
- R7: Opcode 1000 writes N bytes from the buffer RAM to the bus, and opcode 1010 reads N bytes from the bus into the buffer RAM. N is geometry bits 15:8. The buffer address starts at 0 on each start and increments per byte across opcodes.
- R8: Opcode 1011 pulses RE# low for one cycle and stores the data seen on the edge that raises RE# into the scratch field at the shared pointer.
- R9: Opcodes 1100, 1101, 1110 and 1111 drive no bus cycle while ready is low. Once ready is seen high, they issue command 0, command 1, a buffer read or a single-byte read.
- R10: If ready stays low for L consecutive waiting cycles, where L is geometry bits 31:16, the timeout flag is set. The waited-for action is still carried out, and the flag holds until the next start.
- R11: A start clears done and timeout. Start strobes and register writes made while busy are ignored.
- R12: With N = 0, opcodes 1000 and 1010 make no bus cycle and take one cycle each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| start | input | 1 | Start the program (ignored while busy) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished; cleared by start |
| timeout | output | 1 | A ready wait expired; cleared by start |
| scratch_o | output | 32 | Scratch register contents |
| buf_addr | output | AW | Buffer RAM address |
| buf_we | output | 1 | Buffer RAM write enable |
| buf_wdata | output | 8 | Buffer RAM write data |
| buf_rdata | input | 8 | Buffer RAM read data (combinational) |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Bus data out |
| nf_dq_oe | output | 1 | Bus output enable |
| nf_dq_i | input | 8 | Bus data in |
| nf_rdy | input | 1 | Device ready (high) / busy (low) |

## Verification
The assertions check the bus protocol on every cycle:
- a quiet bus while idle;
- single-cycle WE# and RE# pulses that never overlap;
- CLE and ALE never both high, and the output enable covering every write pulse;
- done only when idle, every end of busy marked by done, and a timeout that does not drop mid-sequence.

Byte values and their order can only be shown by the bench's scenarios, which compare every cycle against a behavioural model. These cover slot order, NOP truncation, command byte selection, address lengths, the shared field pointer, buffer contents, wait and timeout lengths, and writes ignored while busy.

// File: rtl/nand_opseq.sv
module nand_opseq #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic [31:0]   scratch_o,
  output logic [AW-1:0] buf_addr,
  output logic          buf_we,
  output logic [7:0]    buf_wdata,
  input  logic [7:0]    buf_rdata,
  output logic          nf_cle,
  output logic          nf_ale,
  output logic          nf_we_n,
  output logic          nf_re_n,
  output logic [7:0]    nf_dq_o,
  output logic          nf_dq_oe,
  input  logic [7:0]    nf_dq_i,
  input  logic          nf_rdy
);
  logic [31:0] prog, cmds, scratch, col_a, page_a, geom;
  logic [2:0]  slot;
  logic [1:0]  ptr, ci;
  logic [AW-1:0] baddr;
  logic [7:0]  idx, nbytes, dout;
  logic        ph, waited;
  logic [15:0] tmr;
  logic [3:0]  op;
  logic        is_wait, is_cmd, is_addr, is_wr, is_rd, act, use_ptr, use_buf, tmo_hit;

  assign op      = prog[{~slot, 2'b00} +: 4];
  assign is_wait = op[3] & op[2];
  assign is_cmd  = (op[3:2] == 2'b01) || op == 4'd12 || op == 4'd13;
  assign is_addr = op inside {4'd1, 4'd2, 4'd3};
  assign is_wr   = is_cmd || is_addr || op == 4'd8 || op == 4'd9;
  assign is_rd   = op inside {4'd10, 4'd11, 4'd14, 4'd15};
  assign use_ptr = op inside {4'd3, 4'd9, 4'd11, 4'd15};
  assign use_buf = op inside {4'd8, 4'd10, 4'd14};
  assign ci      = op[3] ? {1'b0, op[0]} : op[1:0];
  assign tmo_hit = ({1'b0, tmr} + 17'd1) >= {1'b0, geom[31:16]};

  always_comb begin
    case (op)
      4'd1:                 nbytes = geom[0] ? 8'd2 : 8'd1;
      4'd2:                 nbytes = {6'd0, geom[2:1]} + 8'd1;
      4'd8, 4'd10, 4'd14:   nbytes = geom[15:8];
      default:              nbytes = 8'd1;
    endcase
    case (op)
      4'd1:       dout = col_a[{idx[1:0], 3'b000} +: 8];
      4'd2:       dout = page_a[{idx[1:0], 3'b000} +: 8];
      4'd3, 4'd9: dout = scratch[{~ptr, 3'b000} +: 8];
      4'd8:       dout = buf_rdata;
      default:    dout = cmds[{~ci, 3'b000} +: 8];
    endcase
  end

  assign act       = busy && op != 4'd0 && (!is_wait || waited) && nbytes != 8'd0;
  assign nf_cle    = act && is_cmd;
  assign nf_ale    = act && is_addr;
  assign nf_we_n   = !(act && is_wr && !ph);
  assign nf_re_n   = !(act && is_rd && !ph);
  assign nf_dq_oe  = act && is_wr;
  assign nf_dq_o   = dout;
  assign buf_addr  = baddr;
  assign buf_we    = act && !ph && (op == 4'd10 || op == 4'd14);
  assign buf_wdata = nf_dq_i;
  assign scratch_o = scratch;

  logic unused_ok;
  assign unused_ok = ^geom[7:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog <= '0; cmds <= '0; scratch <= '0; col_a <= '0; page_a <= '0; geom <= '0;
      busy <= 1'b0; done <= 1'b0; timeout <= 1'b0;
      slot <= '0; ptr <= '0; baddr <= '0; idx <= '0; ph <= 1'b0; waited <= 1'b0; tmr <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1; done <= 1'b0; timeout <= 1'b0;
        slot <= '0; ptr <= '0; baddr <= '0; idx <= '0; ph <= 1'b0; waited <= 1'b0; tmr <= '0;
      end else if (cfg_we) begin
        case (cfg_sel)
          3'd0: prog    <= cfg_wdata;
          3'd1: cmds    <= cfg_wdata;
          3'd2: scratch <= cfg_wdata;
          3'd3: col_a   <= cfg_wdata;
          3'd4: page_a  <= cfg_wdata;
          3'd5: geom    <= cfg_wdata;
          default: ;
        endcase
      end
    end else if (op == 4'd0) begin
      busy <= 1'b0; done <= 1'b1;
    end else if (is_wait && !waited) begin
      if (nf_rdy || tmo_hit) begin
        waited <= 1'b1;
        if (!nf_rdy) timeout <= 1'b1;
      end else begin
        tmr <= tmr + 16'd1;
      end
    end else begin
      if (!ph && nbytes != 8'd0) begin
        ph <= 1'b1;
        if (op == 4'd11 || op == 4'd15) scratch[{~ptr, 3'b000} +: 8] <= nf_dq_i;
      end else begin
        ph <= 1'b0;
        if (nbytes != 8'd0) begin
          if (use_ptr) ptr <= ptr + 2'd1;
          if (use_buf) baddr <= baddr + 1'b1;
        end
        if (nbytes == 8'd0 || idx == nbytes - 8'd1) begin
          idx <= '0; waited <= 1'b0; tmr <= '0; slot <= slot + 3'd1;
          if (slot == 3'd7) begin busy <= 1'b0; done <= 1'b1; end
        end else begin
          idx <= idx + 8'd1;
        end
      end
    end
  end
endmodule

module nand_opseq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic timeout,
  input logic nf_cle,
  input logic nf_ale,
  input logic nf_we_n,
  input logic nf_re_n,
  input logic nf_dq_oe
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_dq_oe));
  // R4
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) !nf_we_n |=> nf_we_n);
  // R8
  re_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) !nf_re_n |=> nf_re_n);
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!nf_we_n && !nf_re_n));
  // R5
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(nf_cle && nf_ale));
  // R6
  drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n) !nf_we_n |-> nf_dq_oe);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R2
  end_marks_done_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  // R10
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) (timeout && busy) |=> timeout);
endmodule

bind nand_opseq nand_opseq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .timeout(timeout),
  .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_oe(nf_dq_oe)
);

// File: tb/nand_opseq_tb_top.sv
module nand_opseq_tb_top;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg_we, start, nf_rdy;
  logic [2:0] cfg_sel;
  logic [31:0] cfg_wdata;
  logic [7:0] nf_dq_i = 8'h3C;
  logic busy, done, timeout, buf_we, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [31:0] scratch_o;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_wdata, buf_rdata, nf_dq_o;

  nand_opseq #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .start(start), .busy(busy), .done(done), .timeout(timeout), .scratch_o(scratch_o),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i), .nf_rdy(nf_rdy)
  );

  logic [7:0] ram [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) ram[i] <= 8'(i * 7 + 3);
    end else if (buf_we) begin
      ram[buf_addr] <= buf_wdata;
    end
  end
  assign buf_rdata = ram[buf_addr];

  always @(negedge clk) nf_dq_i <= nf_dq_i * 8'd5 + 8'd17;

  int tests = 0, fails = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_prog = 0, m_cmd = 0, m_col = 0, m_page = 0, m_geom = 0, e_scr = 0;
  logic [7:0] exp_ram [256];
  logic e_busy = 0, e_done = 0, e_to = 0, e_cle = 0, e_ale = 0, e_we_n = 1, e_re_n = 1, e_oe = 0, e_bwe = 0;
  logic [7:0] e_dq = 0, e_baddr = 0;

  task automatic set_idle();
    e_cle = 0; e_ale = 0; e_we_n = 1; e_re_n = 1; e_oe = 0; e_bwe = 0;
  endtask

  function automatic int op_len(input logic [3:0] op);
    if (op == 4'd1) return m_geom[0] ? 2 : 1;
    if (op == 4'd2) return int'(m_geom[2:1]) + 1;
    if (op == 4'd8 || op == 4'd10 || op == 4'd14) return int'(m_geom[15:8]);
    return 1;
  endfunction

  task automatic run_model();
    int ptr = 0, ba = 0, lim, n;
    bit nop = 0;
    logic [3:0] op;
    bit cmd, adr, wr, rd;
    e_busy = 1; e_done = 0; e_to = 0;
    lim = int'(m_geom[31:16]);
    for (int s = 0; s < 8; s++) begin
      op = m_prog[4*(7-s) +: 4];
      if (op == 4'd0) begin nop = 1; break; end
      if (op >= 4'd12) begin
        int t = 0;
        set_idle();
        forever begin
          @(posedge clk);
          if (nf_rdy) break;
          t++;
          if (t >= lim) begin e_to = 1; break; end
        end
      end
      n = op_len(op);
      if (n == 0) begin set_idle(); @(posedge clk); continue; end
      cmd = (op >= 4 && op <= 7) || op == 12 || op == 13;
      adr = op >= 1 && op <= 3;
      wr  = cmd || adr || op == 8 || op == 9;
      rd  = op == 10 || op == 11 || op == 14 || op == 15;
      for (int b = 0; b < n; b++) begin
        if (cmd) e_dq = m_cmd[8*(3 - ((op >= 12) ? int'(op[0]) : int'(op[1:0]))) +: 8];
        else if (op == 1) e_dq = m_col[8*b +: 8];
        else if (op == 2) e_dq = m_page[8*b +: 8];
        else if (op == 3 || op == 9) e_dq = e_scr[8*(3-ptr) +: 8];
        else if (op == 8) e_dq = exp_ram[ba];
        e_cle = cmd; e_ale = adr; e_oe = wr; e_we_n = !wr; e_re_n = !rd;
        e_bwe = (op == 10 || op == 14); e_baddr = 8'(ba);
        @(posedge clk);
        if (op == 11 || op == 15) e_scr[8*(3-ptr) +: 8] = nf_dq_i;
        if (op == 10 || op == 14) exp_ram[ba] = nf_dq_i;
        e_we_n = 1; e_re_n = 1; e_bwe = 0;
        @(posedge clk);
        if (op == 3 || op == 9 || op == 11 || op == 15) ptr = (ptr + 1) % 4;
        if (op == 8 || op == 10 || op == 14) ba = (ba + 1) % 256;
      end
    end
    if (nop) begin set_idle(); @(posedge clk); end
    set_idle();
    e_busy = 0; e_done = 1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_ram[i] = 8'(i * 7 + 3);
    forever begin
      @(posedge clk);
      if (rst_n && !e_busy) begin
        if (start) run_model();
        else if (cfg_we) begin
          case (cfg_sel)
            3'd0: m_prog = cfg_wdata;
            3'd1: m_cmd = cfg_wdata;
            3'd2: e_scr = cfg_wdata;
            3'd3: m_col = cfg_wdata;
            3'd4: m_page = cfg_wdata;
            3'd5: m_geom = cfg_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  // per-cycle comparison and bus monitors
  int cle_cyc = 0, ale_cyc = 0, we_cyc = 0, re_cyc = 0, busy_cyc = 0;
  logic [7:0] last_cmd = 0, last_ale = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 busy", 32'(busy), 32'(e_busy));
      chk("R3 done", 32'(done), 32'(e_done));
      chk("R10 timeout", 32'(timeout), 32'(e_to));
      chk("R4 cle", 32'(nf_cle), 32'(e_cle));
      chk("R5 ale", 32'(nf_ale), 32'(e_ale));
      chk("R4 we_n", 32'(nf_we_n), 32'(e_we_n));
      chk("R8 re_n", 32'(nf_re_n), 32'(e_re_n));
      chk("R6 dq_oe", 32'(nf_dq_oe), 32'(e_oe));
      chk("R7 buf_we", 32'(buf_we), 32'(e_bwe));
      chk("R8 scratch", scratch_o, e_scr);
      if (e_oe) chk("R7 dq_o", 32'(nf_dq_o), 32'(e_dq));
      if (e_bwe) chk("R7 buf_addr", 32'(buf_addr), 32'(e_baddr));
      if (nf_cle) cle_cyc++;
      if (nf_ale) ale_cyc++;
      if (!nf_we_n) we_cyc++;
      if (!nf_re_n) re_cyc++;
      if (busy) busy_cyc++;
      if (nf_cle && !nf_we_n) last_cmd = nf_dq_o;
      if (nf_ale && !nf_we_n) last_ale = nf_dq_o;
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic go();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask
  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask
  task automatic clr();
    cle_cyc = 0; ale_cyc = 0; we_cyc = 0; re_cyc = 0; busy_cyc = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=hung expected=sequence end");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; start = 0; nf_rdy = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 timeout", 32'(timeout), 0);
    chk("R1 strobes", {30'd0, nf_we_n, nf_re_n}, 32'd3);
    chk("R1 latches", {29'd0, nf_cle, nf_ale, nf_dq_oe}, 0);
    chk("R1 scratch", scratch_o, 0);

    // R1: command bytes reset to zero
    wr(0, 32'h4000_0000); last_cmd = 8'hFF; go(); wait_idle();
    chk("R1 cmd0 reset", 32'(last_cmd), 0);

    // R4: four command bytes in order
    wr(1, 32'hA1B2_C3D4); wr(0, 32'h4567_0000); clr(); go(); wait_idle();
    chk("R4 cle cycles", cle_cyc, 8);
    chk("R4 last cmd", 32'(last_cmd), 32'hD4);

    // R5: address lengths
    wr(3, 32'h0000_3412); wr(4, 32'h7856_3412);
    wr(5, {16'd200, 8'd5, 5'd0, 2'd2, 1'b1}); wr(0, 32'h1200_0000);
    clr(); go(); wait_idle();
    chk("R5 long addr ale cycles", ale_cyc, 10);
    chk("R5 last page byte", 32'(last_ale), 32'h56);
    wr(5, {16'd200, 8'd5, 8'd0}); clr(); go(); wait_idle();
    chk("R5 short addr ale cycles", ale_cyc, 4);

    // R6 / R8: shared field pointer
    wr(2, 32'h1122_3344); wr(0, 32'h39B3_9000); go(); wait_idle();
    chk("R6 field0 kept", 32'(scratch_o[31:24]), 32'h11);
    chk("R6 field1 kept", 32'(scratch_o[23:16]), 32'h22);
    chk("R6 field3 kept", 32'(scratch_o[7:0]), 32'h44);
    chk("R6 ua field3", 32'(last_ale), 32'h44);
    chk("R8 read into field2", scratch_o, e_scr);

    // R7: buffer bursts
    wr(0, 32'h8A80_0000); clr(); go(); wait_idle();
    chk("R7 write pulses", we_cyc, 10);
    chk("R7 read pulses", re_cyc, 5);
    for (int i = 0; i < 16; i++) chk("R7 buffer byte", 32'(ram[i]), 32'(exp_ram[i]));

    // R9: wait for ready
    wr(5, {16'd100, 8'd2, 8'd0}); wr(0, 32'hCDEF_0000);
    nf_rdy = 0; go();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9 no strobe while busy-low", {30'd0, nf_we_n, nf_re_n}, 32'd3);
    end
    nf_rdy = 1; wait_idle();
    chk("R9 no timeout", 32'(timeout), 0);
    chk("R9 cw1 issued", 32'(last_cmd), 32'hB2);

    // R10: timeout
    wr(5, {16'd4, 8'd2, 8'd0}); wr(0, 32'hC000_0000);
    nf_rdy = 0; clr(); go(); wait_idle();
    chk("R10 timeout set", 32'(timeout), 1);
    chk("R10 done", 32'(done), 1);
    chk("R10 busy length", busy_cyc, 7);
    chk("R10 cmd0 after timeout", 32'(last_cmd), 32'hA1);

    // R11: start clears status
    nf_rdy = 1; wr(0, 32'h4000_0000); go();
    chk("R11 done cleared", 32'(done), 0);
    chk("R11 timeout cleared", 32'(timeout), 0);
    wait_idle();

    // R11: writes and start while busy are ignored
    wr(5, {16'd40, 8'd2, 8'd0}); wr(0, 32'hC000_0000);
    nf_rdy = 0; go();
    @(negedge clk); cfg_we = 1; cfg_sel = 1; cfg_wdata = 32'h5566_7788; start = 1;
    @(negedge clk); cfg_we = 0; start = 0;
    wait_idle(); nf_rdy = 1;
    wr(0, 32'h4000_0000); last_cmd = 0; clr(); go(); wait_idle();
    chk("R11 cmd unchanged", 32'(last_cmd), 32'hA1);
    chk("R11 single run", busy_cyc, 3);

    // R12: zero transfer count
    wr(5, {16'd40, 8'd0, 8'd0}); wr(0, 32'h8A40_0000);
    clr(); go(); wait_idle();
    chk("R12 no reads", re_cyc, 0);
    chk("R12 one write", we_cyc, 1);
    chk("R12 busy length", busy_cyc, 5);

    // R2: eight slots
    wr(0, 32'h4545_4545); clr(); go(); wait_idle();
    chk("R2 busy length", busy_cyc, 16);
    chk("R2 done", 32'(done), 1);

    // R3: NOP truncates
    wr(0, 32'h4404_4000); clr(); go(); wait_idle();
    chk("R3 cle cycles", cle_cyc, 4);
    chk("R3 busy length", busy_cyc, 5);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule